// File: doc/BRIEF.md
# Reader Interrupt Request Controller

This block gathers completion and level conditions from the units of a contactless reader front end and turns them into six sticky interrupt flags. The units are a countdown timer, the transmitter, a CRC engine, an EEPROM programmer, the receiver, the command sequencer and a FIFO level monitor. Each unit presents a plain level or state signal. The block registers the previous value of every signal and reacts to the step that marks an event. A flag stays latched until the host microprocessor clears it.

The host reaches the block through a small register port. One register holds the flags and is cleared by writing 1s. A second holds the per-flag enable mask. A third holds the pin polarity. When any flag is set and enabled, a summary bit goes high. A registered interrupt pin follows that summary, at a level chosen by the polarity register. The flag order in the registers is: bit 0 timer, bit 1 transmit, bit 2 receive, bit 3 idle, bit 4 FIFO high alert, bit 5 FIFO low alert.

Top module: `rdr_irq_ctrl`

## Requirements
- R1: While reset is held and after it is released, the flags, the enable mask and the polarity all read 0, and `irq_pin` sits at 1, which is the inactive level for the active-low default. No event is taken on the first clock edge after reset is released.
- R2: With `tmr_reload_en`=0, the timer flag (bit 0) sets when `tmr_count` steps from 1 to 0.
- R3: With `tmr_reload_en`=1, the timer flag sets when `tmr_count` steps from 1 to `tmr_preload`. In this mode a step from 1 to 0 does not set the flag.
- R4: The transmit flag (bit 1) sets when `tx_state` moves from 1 (sending data) to 2 (sending end of frame). A move from any other state into 2 does not set it.
- R5: The transmit flag also sets on a rising edge of `crc_ready` or of `ee_ready`. A ready signal that stays high does not set the flag again after a clear.
- R6: The receive flag (bit 2) sets on a rising edge of `rx_end`.
- R7: The idle flag (bit 3) sets when `cmd_code` changes from a non-zero value to 0, the idle command code.
- R8: The high-alert flag (bit 4) sets when `fifo_level >= 64 - water_level` becomes true. The low-alert flag (bit 5) sets when `fifo_level <= water_level` becomes true. A condition that is already true when reset is released sets nothing.
- R9: A flag stays set after its source goes away. Writing address 0 clears each flag whose data bit is 1. A set event in the same cycle as its clear leaves the flag set.
- R10: `irq_summary`, and bit 7 of the address 0 read, equal the OR of the flags ANDed with the enable mask, in the same cycle as the flags.
- R11: `irq_pin` takes, one cycle later, the summary when polarity (address 2, bit 0) is 1, and its inverse when polarity is 0.
- R12: Reads are combinational. Address 0 gives {summary, 0, flags}, address 1 gives the enable mask in bits 5:0, address 2 gives the polarity in bit 0, and address 3 gives 0. A write to address 1 or 2 takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_count | input | CNT_W | Current countdown timer value |
| tmr_reload_en | input | 1 | Timer auto-restart mode |
| tmr_preload | input | CNT_W | Timer reload value |
| tx_state | input | 2 | Transmitter state: 0 idle, 1 data, 2 end of frame, 3 other |
| crc_ready | input | 1 | CRC engine done level |
| ee_ready | input | 1 | EEPROM programming done level |
| rx_end | input | 1 | Receiver end-of-stream level |
| cmd_code | input | CMD_W | Command register contents, 0 means idle |
| fifo_level | input | LVL_W | FIFO fill count, 0 to FIFO_DEPTH |
| water_level | input | LVL_W | FIFO alert margin |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data |
| irq_summary | output | 1 | OR of enabled flags |
| irq_pin | output | 1 | Registered interrupt pin |

## Verification
The event checks assume that `water_level` never exceeds the FIFO depth. They also assume that `tmr_preload` is never 1 while auto-restart is on, because a count that stays at 1 would otherwise count as a reload step on every cycle. The random stimulus respects both limits: it keeps the water level between 0 and 32 and the preload between 2 and 12. The timer moves as a plausible countdown, and the FIFO level moves as a random walk with occasional jumps. Host writes arrive at random and often fall in the same cycle as an event, which exercises the rule that a set beats a clear.

// File: rtl/rdr_irq_pkg.sv
package rdr_irq_pkg;

    localparam int NFLAG  = 6;
    localparam int F_TMR  = 0;
    localparam int F_TX   = 1;
    localparam int F_RX   = 2;
    localparam int F_IDLE = 3;
    localparam int F_HI   = 4;
    localparam int F_LO   = 5;

    typedef enum logic [1:0] {
        TXS_IDLE = 2'd0,
        TXS_DATA = 2'd1,
        TXS_EOF  = 2'd2,
        TXS_MISC = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        ADR_FLAG = 2'd0,
        ADR_EN   = 2'd1,
        ADR_POL  = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/rdr_irq_events.sv
module rdr_irq_events
    import rdr_irq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int CMD_W      = 6,
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = 7,
    parameter logic [CMD_W-1:0] IDLE_CMD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic             tmr_reload_en,
    input  logic [CNT_W-1:0] tmr_preload,
    input  logic [1:0]       tx_state,
    input  logic             crc_ready,
    input  logic             ee_ready,
    input  logic             rx_end,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] water_level,
    output logic [NFLAG-1:0] ev_o
);

    typedef struct packed {
        logic             primed;
        logic [CNT_W-1:0] tmr;
        logic [1:0]       tx;
        logic             crc;
        logic             ee;
        logic             rx;
        logic [CMD_W-1:0] cmd;
        logic             hi;
        logic             lo;
    } hist_t;

    hist_t            st_d, st_q;
    logic             hi_now, lo_now;
    logic [CNT_W-1:0] tmr_target;
    logic [NFLAG-1:0] ev;

    always_comb begin
        hi_now     = int'(fifo_level) >= (FIFO_DEPTH - int'(water_level));
        lo_now     = int'(fifo_level) <= int'(water_level);
        tmr_target = tmr_reload_en ? tmr_preload : '0;

        ev         = '0;
        ev[F_TMR]  = (st_q.tmr == CNT_W'(1)) && (tmr_count == tmr_target);
        ev[F_TX]   = ((st_q.tx == TXS_DATA) && (tx_state == TXS_EOF))
                   || (crc_ready && !st_q.crc)
                   || (ee_ready && !st_q.ee);
        ev[F_RX]   = rx_end && !st_q.rx;
        ev[F_IDLE] = (st_q.cmd != IDLE_CMD) && (cmd_code == IDLE_CMD);
        ev[F_HI]   = hi_now && !st_q.hi;
        ev[F_LO]   = lo_now && !st_q.lo;
        if (!st_q.primed) begin
            ev = '0;
        end

        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.tmr    = tmr_count;
        st_d.tx     = tx_state;
        st_d.crc    = crc_ready;
        st_d.ee     = ee_ready;
        st_d.rx     = rx_end;
        st_d.cmd    = cmd_code;
        st_d.hi     = hi_now;
        st_d.lo     = lo_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev_o = ev;

    // R2 / R3: a timer event always follows a sampled count of one
    a_r2_timer_from_one: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[F_TMR] |-> ($past(tmr_count) == CNT_W'(1)));

    // R7: idle event only on the step from a busy code to the idle code
    a_r7_idle_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[F_IDLE] |-> (($past(cmd_code) != IDLE_CMD) && (cmd_code == IDLE_CMD)));

    // R6: receive event needs a low-to-high step of rx_end
    a_r6_rx_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[F_RX] |-> (rx_end && !$past(rx_end)));

endmodule

// File: rtl/rdr_irq_regs.sv
module rdr_irq_regs
    import rdr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] ev,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             summary_o,
    output logic             pin_o
);

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] en;
        logic             pol;
        logic             pin;
    } irq_regs_t;

    irq_regs_t        st_d, st_q;
    reg_addr_e        sel;
    logic [NFLAG-1:0] clr;
    logic             summary;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[7:NFLAG];

    always_comb begin
        sel     = reg_addr_e'(addr);
        summary = |(st_q.flags & st_q.en);
        clr     = (we && sel == ADR_FLAG) ? wdata[NFLAG-1:0] : '0;

        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr) | ev;
        if (we && sel == ADR_EN) begin
            st_d.en = wdata[NFLAG-1:0];
        end
        if (we && sel == ADR_POL) begin
            st_d.pol = wdata[0];
        end
        st_d.pin = st_q.pol ? summary : ~summary;

        case (sel)
            ADR_FLAG: rdata = {summary, {(7-NFLAG){1'b0}}, st_q.flags};
            ADR_EN:   rdata = {{(8-NFLAG){1'b0}}, st_q.en};
            ADR_POL:  rdata = {7'd0, st_q.pol};
            default:  rdata = 8'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.pin   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign summary_o = summary;
    assign pin_o     = st_q.pin;

    // R9: a set flag survives unless its bit was written with a one
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.flags) & ~$past(clr)) & ~st_q.flags) == '0));

    // R9: an event leaves its flag set, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((st_q.flags & $past(ev)) == $past(ev)));

    // R9: no flag rises without an event
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags & ~$past(st_q.flags) & ~$past(ev)) == '0));

    // R11: pin tracks the previous summary through the polarity
    a_r11_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_o == ($past(st_q.pol) ? $past(summary) : !$past(summary))));

endmodule

// File: rtl/rdr_irq_ctrl.sv
module rdr_irq_ctrl
    import rdr_irq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int CMD_W      = 6,
    parameter int FIFO_DEPTH = 64,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic             tmr_reload_en,
    input  logic [CNT_W-1:0] tmr_preload,
    input  logic [1:0]       tx_state,
    input  logic             crc_ready,
    input  logic             ee_ready,
    input  logic             rx_end,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] water_level,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq_summary,
    output logic             irq_pin
);

    logic [NFLAG-1:0] ev;

    rdr_irq_events #(
        .CNT_W      (CNT_W),
        .CMD_W      (CMD_W),
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W),
        .IDLE_CMD   ('0)
    ) u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .tmr_count     (tmr_count),
        .tmr_reload_en (tmr_reload_en),
        .tmr_preload   (tmr_preload),
        .tx_state      (tx_state),
        .crc_ready     (crc_ready),
        .ee_ready      (ee_ready),
        .rx_end        (rx_end),
        .cmd_code      (cmd_code),
        .fifo_level    (fifo_level),
        .water_level   (water_level),
        .ev_o          (ev)
    );

    rdr_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .summary_o (irq_summary),
        .pin_o     (irq_pin)
    );

    // R10: summary agrees with the readable status bit
    a_r10_summary_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[7] == irq_summary));

endmodule

// File: tb/tb_rdr_irq_ctrl.sv
module tb_rdr_irq_ctrl;

    localparam int CNT_W = 8;
    localparam int CMD_W = 6;
    localparam int DEPTH = 64;
    localparam int LVL_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] tmr_count, tmr_preload;
    logic             tmr_reload_en;
    logic [1:0]       tx_state;
    logic             crc_ready, ee_ready, rx_end;
    logic [CMD_W-1:0] cmd_code;
    logic [LVL_W-1:0] fifo_level, water_level;
    logic             reg_we;
    logic [1:0]       reg_addr;
    logic [7:0]       reg_wdata;
    logic [7:0]       reg_rdata;
    logic             irq_summary, irq_pin;

    always #10 clk = ~clk;

    rdr_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .tmr_count(tmr_count), .tmr_reload_en(tmr_reload_en), .tmr_preload(tmr_preload),
        .tx_state(tx_state), .crc_ready(crc_ready), .ee_ready(ee_ready), .rx_end(rx_end),
        .cmd_code(cmd_code), .fifo_level(fifo_level), .water_level(water_level),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_summary(irq_summary), .irq_pin(irq_pin)
    );

    int vectors = 0;
    int fails   = 0;

    // reference state, built from the requirements
    logic [5:0]       m_flags, m_en;
    logic             m_pol, m_pin, m_primed;
    logic [CNT_W-1:0] p_tmr;
    logic [1:0]       p_tx;
    logic             p_crc, p_ee, p_rx, p_hi, p_lo;
    logic [CMD_W-1:0] p_cmd;

    function automatic logic m_sum();
        return |(m_flags & m_en);
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {m_sum(), 1'b0, m_flags};
            2'd1:    return {2'b00, m_en};
            2'd2:    return {7'd0, m_pol};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic hi_cond();
        return int'(fifo_level) >= DEPTH - int'(water_level);
    endfunction

    function automatic logic lo_cond();
        return int'(fifo_level) <= int'(water_level);
    endfunction

    task automatic model_edge();
        logic [5:0] ev, clr;
        logic       npin;
        if (!rst_n) begin
            m_flags = '0; m_en = '0; m_pol = 1'b0; m_pin = 1'b1; m_primed = 1'b0;
            p_tmr = '0; p_tx = '0; p_crc = 0; p_ee = 0; p_rx = 0; p_cmd = '0; p_hi = 0; p_lo = 0;
        end else begin
            ev = '0;
            ev[0] = (p_tmr == 1) && (tmr_count == (tmr_reload_en ? tmr_preload : 8'd0));
            ev[1] = (p_tx == 2'd1 && tx_state == 2'd2) || (crc_ready && !p_crc) || (ee_ready && !p_ee);
            ev[2] = rx_end && !p_rx;
            ev[3] = (p_cmd != 0) && (cmd_code == 0);
            ev[4] = hi_cond() && !p_hi;
            ev[5] = lo_cond() && !p_lo;
            if (!m_primed) ev = '0;
            npin = m_pol ? m_sum() : !m_sum();
            clr = (reg_we && reg_addr == 2'd0) ? reg_wdata[5:0] : 6'd0;
            m_flags = (m_flags & ~clr) | ev;
            if (reg_we && reg_addr == 2'd1) m_en = reg_wdata[5:0];
            if (reg_we && reg_addr == 2'd2) m_pol = reg_wdata[0];
            m_pin = npin;
            p_tmr = tmr_count; p_tx = tx_state; p_crc = crc_ready; p_ee = ee_ready;
            p_rx = rx_end; p_cmd = cmd_code; p_hi = hi_cond(); p_lo = lo_cond();
            m_primed = 1'b1;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rand_drive();
        if ($urandom_range(0, 1) == 1) begin
            if (tmr_count == 1)       tmr_count = tmr_reload_en ? tmr_preload : 8'd0;
            else if (tmr_count == 0) begin
                if ($urandom_range(0, 3) == 0) tmr_count = 8'($urandom_range(1, 12));
            end else                  tmr_count = tmr_count - 8'd1;
        end
        if ($urandom_range(0, 31) == 0) tmr_reload_en = ~tmr_reload_en;
        if ($urandom_range(0, 31) == 0) tmr_preload = 8'($urandom_range(2, 12));
        if ($urandom_range(0, 2) == 0)  tx_state = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 5) == 0)  crc_ready = ~crc_ready;
        if ($urandom_range(0, 5) == 0)  ee_ready = ~ee_ready;
        if ($urandom_range(0, 5) == 0)  rx_end = ~rx_end;
        if ($urandom_range(0, 3) == 0)  cmd_code = 6'($urandom_range(0, 3));
        case ($urandom_range(0, 2))
            0: if (fifo_level > 0) fifo_level = fifo_level - 7'd1;
            1: if (fifo_level < 7'(DEPTH)) fifo_level = fifo_level + 7'd1;
            default: ;
        endcase
        if ($urandom_range(0, 49) == 0) fifo_level = 7'($urandom_range(0, DEPTH));
        if ($urandom_range(0, 63) == 0) water_level = 7'($urandom_range(0, 32));
        reg_we    = ($urandom_range(0, 7) == 0);
        reg_addr  = 2'($urandom_range(0, 3));
        reg_wdata = 8'($urandom);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        tmr_count = '0; tmr_preload = 8'd5; tmr_reload_en = 1'b0;
        tx_state = '0; crc_ready = 0; ee_ready = 0; rx_end = 0; cmd_code = '0;
        fifo_level = '0; water_level = 7'd8;
        reg_we = 0; reg_addr = '0; reg_wdata = '0;
        tick(); tick();

        // R1: reset state
        rd("R1 flags", 2'd0, 8'h00);
        rd("R1 enable", 2'd1, 8'h00);
        rd("R1 polarity", 2'd2, 8'h00);
        check("R1 pin", {7'd0, irq_pin}, 8'h01);
        rst_n = 1'b1;
        tick(); tick();
        // R8: low-alert condition true across reset release sets nothing
        rd("R8 no event at release", 2'd0, 8'h00);
        fifo_level = 7'd32; tick();

        // R2: timer 1 -> 0
        tmr_count = 8'd1; tick();
        tmr_count = 8'd0; tick();
        rd("R2 timer to zero", 2'd0, 8'h01);
        wr(2'd0, 8'h01);
        rd("R9 clear timer", 2'd0, 8'h00);

        // R3: auto-restart, 1 -> 0 ignored, 1 -> preload sets
        tmr_reload_en = 1'b1;
        tmr_count = 8'd1; tick();
        tmr_count = 8'd0; tick();
        rd("R3 zero ignored in reload mode", 2'd0, 8'h00);
        tmr_count = 8'd1; tick();
        tmr_count = 8'd5; tick();
        rd("R3 reload step", 2'd0, 8'h01);
        wr(2'd0, 8'h3F);
        tmr_reload_en = 1'b0; tmr_count = 8'd0;

        // R4: data -> end of frame
        tx_state = 2'd1; tick();
        tx_state = 2'd2; tick();
        rd("R4 data to eof", 2'd0, 8'h02);
        wr(2'd0, 8'h02);
        tx_state = 2'd0; tick();
        tx_state = 2'd2; tick();
        rd("R4 idle to eof ignored", 2'd0, 8'h00);
        tx_state = 2'd0;

        // R5: CRC and EEPROM ready edges
        crc_ready = 1'b1; tick();
        rd("R5 crc ready", 2'd0, 8'h02);
        wr(2'd0, 8'h02);
        tick();
        rd("R5 held ready no repeat", 2'd0, 8'h00);
        ee_ready = 1'b1; tick();
        rd("R5 eeprom ready", 2'd0, 8'h02);
        crc_ready = 0; ee_ready = 0;
        wr(2'd0, 8'h02);

        // R6 and R9 stickiness
        rx_end = 1'b1; tick();
        rd("R6 rx end", 2'd0, 8'h04);
        rx_end = 1'b0; tick();
        rd("R9 sticky after source drops", 2'd0, 8'h04);
        wr(2'd0, 8'h04);

        // R7: command returns to idle
        cmd_code = 6'd3; tick();
        cmd_code = 6'd0; tick();
        rd("R7 idle code", 2'd0, 8'h08);
        wr(2'd0, 8'h08);

        // R8: high then low alert
        fifo_level = 7'd60; tick();
        rd("R8 high alert", 2'd0, 8'h10);
        fifo_level = 7'd4; tick();
        rd("R8 low alert", 2'd0, 8'h30);
        wr(2'd0, 8'h30);
        fifo_level = 7'd32; tick();

        // R10 and R11: summary and registered pin
        wr(2'd1, 8'h3F);
        rx_end = 1'b1; tick();
        check("R10 summary", {7'd0, irq_summary}, 8'h01);
        rd("R10 status bit", 2'd0, 8'h84);
        check("R11 pin lags", {7'd0, irq_pin}, 8'h01);
        tick();
        check("R11 pin active low", {7'd0, irq_pin}, 8'h00);
        wr(2'd2, 8'h01);
        tick();
        check("R11 pin active high", {7'd0, irq_pin}, 8'h01);

        // R12: readback of other registers
        rd("R12 enable read", 2'd1, 8'h3F);
        rd("R12 polarity read", 2'd2, 8'h01);
        rd("R12 unused address", 2'd3, 8'h00);

        // R9: set beats clear in the same cycle
        rx_end = 1'b0; tick();
        rx_end = 1'b1;
        wr(2'd0, 8'h04);
        rd("R9 set wins", 2'd0, 8'h84);
        wr(2'd0, 8'h3F);
        rd("R9 clear all", 2'd0, 8'h00);

        // random phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            rand_drive();
            #1;
            check(reg_addr == 2'd0 ? "R9 flags read" : "R12 register read",
                  reg_rdata, exp_rdata(reg_addr));
            check("R10 summary", {7'd0, irq_summary}, {7'd0, m_sum()});
            check("R11 pin", {7'd0, irq_pin}, {7'd0, m_pin});
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule